// File: doc/BRIEF.md
# Scoreboarded Warp Instruction Scheduler

This block sits between the instruction fetch stage and one execution unit of a multithreaded processor core. Each warp has one instruction buffer slot. A fetch port fills the slot of any warp with a decoded instruction: a destination register, two source registers and an opaque tag. A per-warp scoreboard records which registers have results in flight. A buffered instruction may issue only when none of its three register operands is marked in flight in its own warp.

Each cycle the scheduler chooses at most one eligible warp. The search is round-robin and starts at the warp after the one that issued last. The chosen instruction leaves its slot. Its destination register is marked in flight until a writeback naming that warp and register clears it. One warp instruction occupies the execution unit for `ISSUE_GAP` cycles (default 4). After an issue, no further issue happens until that many cycles have passed. The default size is 24 warps with 16 registers each.

Top module: `warp_issue_sched`

## Requirements
- R1: When reset is released, every buffer slot is empty, no register is marked in flight, `issue_valid` is 0, `fetch_ready` is 1 for every warp, and the first round-robin search starts at warp 0.
- R2: `fetch_ready` is high exactly when the slot of `fetch_warp` is empty. A fetch with `fetch_valid` high and `fetch_ready` high stores the instruction, and it can issue from the next cycle on. A fetch while `fetch_ready` is low is dropped and leaves the stored instruction unchanged.
- R3: At most one instruction is issued per cycle. `issue_valid` together with `issue_warp`, `issue_dst`, `issue_src0`, `issue_src1` and `issue_tag` reports it in the same cycle, and its slot is empty from the next cycle on.
- R4: A buffered instruction is not eligible while its destination register or either of its source registers is marked in flight in its own warp.
- R5: An issue marks its destination register as in flight in the issuing warp, starting with the next cycle.
- R6: A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears the in-flight mark of that register. An instruction that waits only on that register may issue in the same cycle as the writeback. A writeback to a register that is not marked has no effect.
- R7: Among the eligible warps, the one issued is the first found when searching upward from the warp after the last issued warp, wrapping from the highest warp to warp 0.
- R8: After an issue, `issue_valid` stays low for the next `ISSUE_GAP`-1 cycles, whatever is eligible.
- R9: When no buffered instruction is eligible, `issue_valid` is low.
- R10: The scoreboards of the warps are independent. A register in flight in one warp does not block an instruction of another warp that names the same register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A decoded instruction is offered |
| fetch_warp | input | WID_W | Warp whose slot the instruction goes to |
| fetch_dst | input | RID_W | Destination register |
| fetch_src0 | input | RID_W | First source register |
| fetch_src1 | input | RID_W | Second source register |
| fetch_tag | input | TAG_W | Opaque payload carried to issue |
| fetch_ready | output | 1 | Slot of `fetch_warp` is empty |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | WID_W | Warp of the writeback |
| wb_reg | input | RID_W | Register whose mark is cleared |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID_W | Issuing warp |
| issue_dst | output | RID_W | Destination of the issued instruction |
| issue_src0 | output | RID_W | First source of the issued instruction |
| issue_src1 | output | RID_W | Second source of the issued instruction |
| issue_tag | output | TAG_W | Tag of the issued instruction |

## Verification
The bench targets the corner cases where a scheduler most easily goes wrong:
- A writeback that arrives in the same cycle as the dependent instruction would otherwise issue. A design that checks eligibility before applying the clear loses a cycle, and the model sees the issue arrive late.
- A fetch aimed at an occupied slot. A design that stores it anyway overwrites the waiting instruction, and the wrong tag appears at issue.
- Register numbers shared across warps. A scoreboard indexed without the warp stalls unrelated warps.
- Round-robin wrap from the top warp and a full `ISSUE_GAP` window. A search that restarts at warp 0, or a window that is one cycle short, shows up as a different `issue_warp` or an early `issue_valid`.

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 24,
  parameter int NUM_REGS  = 16,
  parameter int TAG_W     = 8,
  parameter int ISSUE_GAP = 4,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int RID_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [WID_W-1:0] fetch_warp,
  input  logic [RID_W-1:0] fetch_dst,
  input  logic [RID_W-1:0] fetch_src0,
  input  logic [RID_W-1:0] fetch_src1,
  input  logic [TAG_W-1:0] fetch_tag,
  output logic             fetch_ready,
  input  logic             wb_valid,
  input  logic [WID_W-1:0] wb_warp,
  input  logic [RID_W-1:0] wb_reg,
  output logic             issue_valid,
  output logic [WID_W-1:0] issue_warp,
  output logic [RID_W-1:0] issue_dst,
  output logic [RID_W-1:0] issue_src0,
  output logic [RID_W-1:0] issue_src1,
  output logic [TAG_W-1:0] issue_tag
);
  localparam int NBITS = NUM_WARPS * NUM_REGS;
  localparam int BIT_W = $clog2(NBITS + 1);
  localparam int GAP_W = $clog2(ISSUE_GAP + 1);

  logic [NUM_WARPS-1:0] slot_v, elig;
  logic [RID_W-1:0]     slot_dst  [NUM_WARPS];
  logic [RID_W-1:0]     slot_src0 [NUM_WARPS];
  logic [RID_W-1:0]     slot_src1 [NUM_WARPS];
  logic [TAG_W-1:0]     slot_tag  [NUM_WARPS];
  logic [NBITS-1:0]     busy, wb_clr, iss_set, eff;
  logic [BIT_W-1:0]     wb_idx, iss_idx;
  logic [GAP_W-1:0]     cool;
  logic [WID_W-1:0]     last_w, sel_w;
  logic                 sel_found, fetch_take;

  assign fetch_ready = (int'(fetch_warp) < NUM_WARPS) && !slot_v[fetch_warp];
  assign fetch_take  = fetch_valid && fetch_ready;

  assign wb_idx  = BIT_W'(int'(wb_warp) * NUM_REGS + int'(wb_reg));
  assign iss_idx = BIT_W'(int'(sel_w) * NUM_REGS + int'(slot_dst[sel_w]));

  always_comb begin
    wb_clr = '0;
    if (wb_valid && int'(wb_warp) < NUM_WARPS) wb_clr[wb_idx] = 1'b1;
  end

  assign eff = busy & ~wb_clr;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
    logic [NUM_REGS-1:0] row;
    assign row = eff[w*NUM_REGS +: NUM_REGS];
    assign elig[w] = slot_v[w] & ~row[slot_dst[w]] & ~row[slot_src0[w]] & ~row[slot_src1[w]];
  end

  always_comb begin
    int c;
    sel_found = 1'b0;
    sel_w     = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      c = int'(last_w) + 1 + i;
      if (c >= NUM_WARPS) c = c - NUM_WARPS;
      if (!sel_found && elig[c]) begin
        sel_found = 1'b1;
        sel_w     = WID_W'(c);
      end
    end
  end

  assign issue_valid = sel_found && (cool == '0);
  assign issue_warp  = sel_w;
  assign issue_dst   = slot_dst[sel_w];
  assign issue_src0  = slot_src0[sel_w];
  assign issue_src1  = slot_src1[sel_w];
  assign issue_tag   = slot_tag[sel_w];

  always_comb begin
    iss_set = '0;
    if (issue_valid) iss_set[iss_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= '0;
      busy   <= '0;
      cool   <= '0;
      last_w <= WID_W'(NUM_WARPS - 1);
    end else begin
      if (fetch_take)  slot_v[fetch_warp] <= 1'b1;
      if (issue_valid) begin
        slot_v[sel_w] <= 1'b0;
        last_w        <= sel_w;
        cool          <= GAP_W'(ISSUE_GAP - 1);
      end else if (cool != '0) begin
        cool <= cool - 1'b1;
      end
      busy <= eff | iss_set;
    end
  end

  always_ff @(posedge clk) begin
    if (fetch_take) begin
      slot_dst[fetch_warp]  <= fetch_dst;
      slot_src0[fetch_warp] <= fetch_src0;
      slot_src1[fetch_warp] <= fetch_src1;
      slot_tag[fetch_warp]  <= fetch_tag;
    end
  end

  // R2
  fetch_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> slot_v[$past(fetch_warp)]);

  // R3
  issue_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !slot_v[$past(issue_warp)]);

  // R5
  dst_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> busy[$past(iss_idx)]);

  // R6
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && int'(wb_warp) < NUM_WARPS && !(issue_valid && iss_idx == wb_idx)
    |=> !busy[$past(wb_idx)]);

  // R8
  if (ISSUE_GAP > 1) begin : g_gap_chk
    issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> !issue_valid);
  end
endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int NW = 24, NR = 16, TW = 8, GAP = 4;
  localparam int WID_W = $clog2(NW), RID_W = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 1'b0, wb_valid = 1'b0;
  logic [WID_W-1:0] fetch_warp = '0, wb_warp = '0;
  logic [RID_W-1:0] fetch_dst = '0, fetch_src0 = '0, fetch_src1 = '0, wb_reg = '0;
  logic [TW-1:0] fetch_tag = '0;
  logic fetch_ready, issue_valid;
  logic [WID_W-1:0] issue_warp;
  logic [RID_W-1:0] issue_dst, issue_src0, issue_src1;
  logic [TW-1:0] issue_tag;

  always #4 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .TAG_W(TW), .ISSUE_GAP(GAP)) dut (
    .clk, .rst_n, .fetch_valid, .fetch_warp, .fetch_dst, .fetch_src0, .fetch_src1,
    .fetch_tag, .fetch_ready, .wb_valid, .wb_warp, .wb_reg, .issue_valid, .issue_warp,
    .issue_dst, .issue_src0, .issue_src1, .issue_tag);

  int n_chk = 0, n_fail = 0;
  int m_v [NW], m_d [NW], m_s0 [NW], m_s1 [NW], m_t [NW];
  bit m_busy [NW][NR];
  int m_last = NW - 1, m_cool = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit effb(int w, int r, bit wv, int ww, int wr);
    return m_busy[w][r] && !(wv && ww == w && wr == r);
  endfunction

  task automatic step(bit fv, int fw, int fd, int fs0, int fs1, int ft,
                      bit wv, int ww, int wr, string req);
    bit ev, er; int ew;
    @(negedge clk);
    fetch_valid = fv; fetch_warp = WID_W'(fw); fetch_dst = RID_W'(fd);
    fetch_src0 = RID_W'(fs0); fetch_src1 = RID_W'(fs1); fetch_tag = TW'(ft);
    wb_valid = wv; wb_warp = WID_W'(ww); wb_reg = RID_W'(wr);
    #2;
    ev = 0; ew = 0;
    if (m_cool == 0)
      for (int i = 0; i < NW; i++) begin
        int c = (m_last + 1 + i) % NW;
        if (!ev && m_v[c] && !effb(c, m_d[c], wv, ww, wr) && !effb(c, m_s0[c], wv, ww, wr)
            && !effb(c, m_s1[c], wv, ww, wr)) begin
          ev = 1; ew = c;
        end
      end
    er = !m_v[fw];
    chk(req, "fetch_ready", int'(fetch_ready), int'(er));
    chk(req, "issue_valid", int'(issue_valid), int'(ev));
    if (ev && issue_valid) begin
      chk(req, "issue_warp", int'(issue_warp), ew);
      chk(req, "issue_dst", int'(issue_dst), m_d[ew]);
      chk(req, "issue_src0", int'(issue_src0), m_s0[ew]);
      chk(req, "issue_src1", int'(issue_src1), m_s1[ew]);
      chk(req, "issue_tag", int'(issue_tag), m_t[ew]);
    end
    @(posedge clk);
    if (wv) m_busy[ww][wr] = 0;
    if (ev) begin
      m_v[ew] = 0; m_last = ew; m_cool = GAP - 1; m_busy[ew][m_d[ew]] = 1;
    end else if (m_cool > 0) m_cool--;
    if (fv && er) begin
      m_v[fw] = 1; m_d[fw] = fd; m_s0[fw] = fs0; m_s1[fw] = fs1; m_t[fw] = ft;
    end
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_v[w] = 0; m_d[w] = 0; m_s0[w] = 0; m_s1[w] = 0; m_t[w] = 0;
      for (int r = 0; r < NR; r++) m_busy[w][r] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: empty after reset, every slot ready
    for (int w = 0; w < NW; w++) step(0, w, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2: fill warp 3, then retry while occupied (dropped)
    step(1, 3, 5, 1, 2, 8'hA5, 0, 0, 0, "R2");
    step(1, 3, 9, 9, 9, 8'h11, 0, 0, 0, "R2 R3");
    idle(4, "R8");
    // R4 R5: dependent on reg 5 of warp 3 waits
    step(1, 3, 6, 5, 0, 8'h22, 0, 0, 0, "R4");
    idle(3, "R4 R9");
    // R10: warp 4 uses reg 5 freely
    step(1, 4, 7, 5, 5, 8'h33, 0, 0, 0, "R10");
    idle(4, "R10 R8");
    // R6: unrelated writeback no effect, then same-cycle clear issues
    step(0, 0, 0, 0, 0, 0, 1, 3, 12, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 3, 5, "R6");
    idle(4, "R8");
    // R7: round-robin order and wrap, with gap
    step(1, 23, 1, 0, 0, 1, 1, 3, 6, "R7");
    step(1, 0, 1, 0, 0, 2, 1, 4, 7, "R7");
    step(1, 2, 1, 0, 0, 3, 0, 0, 0, "R7");
    step(1, 10, 1, 0, 0, 4, 0, 0, 0, "R7");
    idle(20, "R7 R8");
    for (int w = 0; w < NW; w++) step(0, 0, 0, 0, 0, 0, 1, w, 1, "R6");
    for (int w = 0; w < NW; w++) step(1, w, 2, 3, 4, w, 0, 0, 0, "R7 R8");
    idle(100, "R7 R8");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit fv, wv; int fw, ww, wr, cnt, pick;
      fv = ($urandom_range(0, 9) < 6);
      fw = ($urandom_range(0, 3) == 0) ? $urandom_range(0, NW - 1) : $urandom_range(0, 5);
      wv = ($urandom_range(0, 9) < 5);
      ww = $urandom_range(0, NW - 1); wr = $urandom_range(0, NR - 1);
      cnt = 0;
      for (int w = 0; w < NW; w++) for (int r = 0; r < NR; r++) if (m_busy[w][r]) cnt++;
      if (cnt > 0 && $urandom_range(0, 3) != 0) begin
        pick = $urandom_range(0, cnt - 1);
        for (int w = 0; w < NW; w++) for (int r = 0; r < NR; r++)
          if (m_busy[w][r]) begin
            if (pick == 0) begin ww = w; wr = r; end
            pick--;
          end
      end
      step(fv, fw, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 4),
           $urandom_range(0, 255), wv, ww, wr, "R3 R4 R5 R6 R7 R8 R9 R10");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule